// File: doc/BRIEF.md
# Paged Memory Address Translator

This block sits between an 8-bit processor with a 16-bit address bus and a 1 MB physical memory system. It holds one 8-bit page register for each 4 KB slice of the processor's address space. On every access the top four address bits pick a register, and that register's value is joined with the low twelve address bits to form a 20-bit physical address. The translated page is then decoded into chip selects for a monitor ROM, an I/O page holding five peripheral slots, an 8 KB on-chip RAM window and the external RAM. The read byte returned to the processor comes from whichever source is selected.

Software changes the map by writing into a fixed 256-byte window at the very top of the processor's address space (high address byte 0xFF). Accesses to that window are never translated: reads there always reach the monitor ROM. A write there loads the page register named by the low four address bits. The registers cannot be read back. The low nibble of each stored value reaches the translation path inverted. At reset every register is loaded so that the 64 KB space maps onto itself.

Top module: `page_xlat_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first register write, an access outside the window at address A yields phys_addr = {4'h0, A}.
- R2: Outside the window, phys_addr = {page, cpu_addr[11:0]}, where page is the effective value of the register selected by cpu_addr[15:12].
- R3: A processor write (cpu_vma=1, cpu_rw=0) with cpu_addr[15:8]=0xFF loads register cpu_addr[3:0] with cpu_wdata at that clock edge. Accesses in the following cycle see the new mapping.
- R4: The effective page of a register written with byte D is {D[7:4], ~D[3:0]}.
- R5: When cpu_addr[15:8]=0xFF, phys_addr = {8'hFF, cpu_addr[11:0]} and rom_sel is the only select that may assert, whatever the page registers hold.
- R6: Outside the window, a page whose low nibble is 0xF asserts rom_sel.
- R7: Outside the window, a page whose low nibble is 0xE is the I/O page. If cpu_addr[11:8]=0, cpu_addr[7:4] picks the slot: 0x0 serial_sel, 0x2 kbd_sel, 0x3 video_sel, 0xA panel_sel, 0xB segdisp_sel. Any other slot, or a nonzero cpu_addr[11:8], asserts no select.
- R8: Outside the window, a page whose bits [7:1] equal 7'b0000110 (physical 0x0C000 to 0x0DFFF) asserts iram_sel.
- R9: Outside the window, every page not covered by R6, R7 or R8 asserts xram_sel.
- R10: With cpu_vma=0 all eight selects are low.
- R11: At most one select is high. cpu_rdata equals the read bus of the asserted select, and is 0x00 when none is asserted.
- R12: A write with cpu_vma=0, a read in the window, or a write outside the window leaves every page register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Asynchronous reset, active high |
| cpu_addr | input | 16 | Logical address |
| cpu_wdata | input | 8 | Write data from the processor |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_vma | input | 1 | Valid memory address strobe |
| phys_addr | output | 20 | Translated physical address |
| rom_sel | output | 1 | Monitor ROM select |
| serial_sel | output | 1 | Serial port slot select |
| kbd_sel | output | 1 | Keyboard slot select |
| video_sel | output | 1 | Video slot select |
| panel_sel | output | 1 | Switches/LEDs slot select |
| segdisp_sel | output | 1 | Seven-segment slot select |
| iram_sel | output | 1 | On-chip RAM select |
| xram_sel | output | 1 | External RAM select |
| rom_rdata | input | 8 | ROM read data |
| serial_rdata | input | 8 | Serial port read data |
| kbd_rdata | input | 8 | Keyboard read data |
| video_rdata | input | 8 | Video read data |
| panel_rdata | input | 8 | Switch read data |
| segdisp_rdata | input | 8 | Seven-segment read data |
| iram_rdata | input | 8 | On-chip RAM read data |
| xram_rdata | input | 8 | External RAM read data |
| cpu_rdata | output | 8 | Read data to the processor |

## Verification
The bench programs mappings that land on every region, including 0x0C, 0x0D and pages whose high nibble hides an 0xE or 0xF low nibble. A design that dropped the nibble inversion, or that compared the whole byte instead of the low nibble, would route these accesses to the wrong select. It sweeps all sixteen I/O slots and a nonzero cpu_addr[11:8]. This catches a slot decode that ignores the upper offset bits or lets the reserved slots fall through to external RAM. It writes with cpu_vma low, reads inside the window and stores outside it, then re-sweeps the map. A register file that loaded on any of these would return a changed phys_addr. Window accesses are issued after page 0xF has been remapped, so a design that translated the window would leave rom_sel low or alter phys_addr.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  localparam int PG_W = 8;
  localparam int NSEL = 8;

  // select vector bit positions
  localparam int SEL_ROM     = 0;
  localparam int SEL_SERIAL  = 1;
  localparam int SEL_KBD     = 2;
  localparam int SEL_VIDEO   = 3;
  localparam int SEL_PANEL   = 4;
  localparam int SEL_SEGDISP = 5;
  localparam int SEL_IRAM    = 6;
  localparam int SEL_XRAM    = 7;

  typedef logic [NSEL-1:0] sel_vec_t;
  typedef logic [PG_W-1:0] page_t;

  localparam logic [3:0] NIB_ROM  = 4'hF;
  localparam logic [3:0] NIB_IO   = 4'hE;
  localparam logic [6:0] IRAM_TAG = 7'b0000110;

  // stored byte -> effective page (low nibble flipped); self-inverse
  function automatic page_t page_view(input page_t raw);
    return {raw[7:4], ~raw[3:0]};
  endfunction

  // device slot decode inside the I/O page
  function automatic sel_vec_t io_slot(input logic [3:0] hi, input logic [3:0] slot);
    sel_vec_t s;
    s = '0;
    if (hi == 4'h0) begin
      case (slot)
        4'h0:    s[SEL_SERIAL]  = 1'b1;
        4'h2:    s[SEL_KBD]     = 1'b1;
        4'h3:    s[SEL_VIDEO]   = 1'b1;
        4'hA:    s[SEL_PANEL]   = 1'b1;
        4'hB:    s[SEL_SEGDISP] = 1'b1;
        default: s = '0;
      endcase
    end
    return s;
  endfunction

  // region decode of a translated page (priority: ROM, I/O, on-chip RAM, external RAM)
  function automatic sel_vec_t page_region(input page_t pg, input logic [3:0] hi,
                                           input logic [3:0] slot);
    sel_vec_t s;
    s = '0;
    if (pg[3:0] == NIB_ROM)       s[SEL_ROM]  = 1'b1;
    else if (pg[3:0] == NIB_IO)   s = io_slot(hi, slot);
    else if (pg[7:1] == IRAM_TAG) s[SEL_IRAM] = 1'b1;
    else                          s[SEL_XRAM] = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/pxu_page_file.sv
module pxu_page_file
  import pxu_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  page_t            wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output page_t            rd_page
);
  localparam int NPG = 1 << IDX_W;

  logic [NPG-1:0][PG_W-1:0] raw_q;

  generate
    for (genvar g = 0; g < NPG; g++) begin : g_entry
      // reset value chosen so the effective page equals the entry index
      localparam page_t RST_RAW = page_view(page_t'(g));
      always_ff @(posedge clk or posedge rst) begin
        if (rst)                                  raw_q[g] <= RST_RAW;
        else if (wr_en && (wr_idx == IDX_W'(g)))  raw_q[g] <= wr_data;
      end
    end
  endgenerate

  assign rd_page = page_view(raw_q[rd_idx]);

  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (raw_q[$past(wr_idx)] == $past(wr_data)));

  p_hold_without_write_r12: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(raw_q));

endmodule

// File: rtl/pxu_region_decode.sv
module pxu_region_decode
  import pxu_pkg::*;
(
  input  logic       vma,
  input  logic       in_window,
  input  page_t      page,
  input  logic [3:0] io_hi,
  input  logic [3:0] io_slot_sel,
  output sel_vec_t   sel
);
  sel_vec_t raw_sel;

  always_comb begin
    if (in_window) begin
      raw_sel = '0;
      raw_sel[SEL_ROM] = 1'b1;
    end else begin
      raw_sel = page_region(page, io_hi, io_slot_sel);
    end
  end

  assign sel = vma ? raw_sel : '0;

endmodule

// File: rtl/pxu_rdata_mux.sv
module pxu_rdata_mux #(
  parameter int NSRC = 8,
  parameter int DW   = 8
) (
  input  logic [NSRC-1:0]    sel,
  input  logic [NSRC*DW-1:0] src,
  output logic [DW-1:0]      rdata
);
  logic [NSRC:0][DW-1:0] acc;

  assign acc[0] = '0;
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_or
      assign acc[g+1] = acc[g] | (src[g*DW +: DW] & {DW{sel[g]}});
    end
  endgenerate

  assign rdata = acc[NSRC];

endmodule

// File: rtl/page_xlat_unit.sv
module page_xlat_unit
  import pxu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [7:0]               cpu_wdata,
  input  logic                     cpu_rw,
  input  logic                     cpu_vma,
  output logic [PG_W+ADDR_W-IDX_W-1:0] phys_addr,
  output logic                     rom_sel,
  output logic                     serial_sel,
  output logic                     kbd_sel,
  output logic                     video_sel,
  output logic                     panel_sel,
  output logic                     segdisp_sel,
  output logic                     iram_sel,
  output logic                     xram_sel,
  input  logic [7:0]               rom_rdata,
  input  logic [7:0]               serial_rdata,
  input  logic [7:0]               kbd_rdata,
  input  logic [7:0]               video_rdata,
  input  logic [7:0]               panel_rdata,
  input  logic [7:0]               segdisp_rdata,
  input  logic [7:0]               iram_rdata,
  input  logic [7:0]               xram_rdata,
  output logic [7:0]               cpu_rdata
);
  localparam int OFS_W  = ADDR_W - IDX_W;
  localparam int PHYS_W = PG_W + OFS_W;
  localparam int WIN_W  = ADDR_W - 8;

  // named internal events
  logic     in_window;
  logic     map_wr;
  page_t    cur_page;
  sel_vec_t sel_vec;

  assign in_window = (cpu_addr[ADDR_W-1:8] == {WIN_W{1'b1}});
  assign map_wr    = in_window && cpu_vma && !cpu_rw;

  pxu_page_file #(.IDX_W(IDX_W)) u_pages (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (map_wr),
    .wr_idx  (cpu_addr[IDX_W-1:0]),
    .wr_data (cpu_wdata),
    .rd_idx  (cpu_addr[ADDR_W-1:OFS_W]),
    .rd_page (cur_page)
  );

  assign phys_addr = in_window ? {{PG_W{1'b1}}, cpu_addr[OFS_W-1:0]}
                               : {cur_page, cpu_addr[OFS_W-1:0]};

  pxu_region_decode u_decode (
    .vma         (cpu_vma),
    .in_window   (in_window),
    .page        (cur_page),
    .io_hi       (cpu_addr[11:8]),
    .io_slot_sel (cpu_addr[7:4]),
    .sel         (sel_vec)
  );

  assign rom_sel     = sel_vec[SEL_ROM];
  assign serial_sel  = sel_vec[SEL_SERIAL];
  assign kbd_sel     = sel_vec[SEL_KBD];
  assign video_sel   = sel_vec[SEL_VIDEO];
  assign panel_sel   = sel_vec[SEL_PANEL];
  assign segdisp_sel = sel_vec[SEL_SEGDISP];
  assign iram_sel    = sel_vec[SEL_IRAM];
  assign xram_sel    = sel_vec[SEL_XRAM];

  pxu_rdata_mux #(.NSRC(NSEL), .DW(8)) u_rmux (
    .sel   (sel_vec),
    .src   ({xram_rdata, iram_rdata, segdisp_rdata, panel_rdata,
             video_rdata, kbd_rdata, serial_rdata, rom_rdata}),
    .rdata (cpu_rdata)
  );

  p_single_select_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_sel, serial_sel, kbd_sel, video_sel, panel_sel, segdisp_sel,
              iram_sel, xram_sel}));

  p_idle_bus_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !cpu_vma |-> !(rom_sel || serial_sel || kbd_sel || video_sel || panel_sel ||
                   segdisp_sel || iram_sel || xram_sel));

  p_window_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (in_window && cpu_vma) |-> (rom_sel && phys_addr[PHYS_W-1:OFS_W] == {PG_W{1'b1}}));

  p_iram_window_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_vma && !in_window && phys_addr[PHYS_W-1:OFS_W+1] == IRAM_TAG) |-> iram_sel);

  p_no_select_zero_data_r11: assert property (@(posedge clk) disable iff (rst)
    !(rom_sel || serial_sel || kbd_sel || video_sel || panel_sel || segdisp_sel ||
      iram_sel || xram_sel) |-> (cpu_rdata == 8'h00));

endmodule

// File: tb/test_page_xlat_unit.sv
module test_page_xlat_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] a;
  logic [7:0]  wd;
  logic        rw, vma;
  logic [7:0]  src [8];
  logic [19:0] phys_addr;
  logic        rom_sel, serial_sel, kbd_sel, video_sel, panel_sel, segdisp_sel;
  logic        iram_sel, xram_sel;
  logic [7:0]  cpu_rdata;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] mdl [16];

  always #10 clk = ~clk;

  page_xlat_unit i_page_xlat_unit (
    .clk(clk), .rst(rst), .cpu_addr(a), .cpu_wdata(wd), .cpu_rw(rw), .cpu_vma(vma),
    .phys_addr(phys_addr),
    .rom_sel(rom_sel), .serial_sel(serial_sel), .kbd_sel(kbd_sel), .video_sel(video_sel),
    .panel_sel(panel_sel), .segdisp_sel(segdisp_sel), .iram_sel(iram_sel),
    .xram_sel(xram_sel),
    .rom_rdata(src[0]), .serial_rdata(src[1]), .kbd_rdata(src[2]), .video_rdata(src[3]),
    .panel_rdata(src[4]), .segdisp_rdata(src[5]), .iram_rdata(src[6]),
    .xram_rdata(src[7]),
    .cpu_rdata(cpu_rdata)
  );

  // bit order: 0 rom,1 serial,2 kbd,3 video,4 panel,5 segdisp,6 iram,7 xram
  function automatic logic [7:0] act_sel();
    return {xram_sel, iram_sel, segdisp_sel, panel_sel, video_sel, kbd_sel,
            serial_sel, rom_sel};
  endfunction

  function automatic logic win(input logic [15:0] ad);
    return ad[15:8] == 8'hFF;
  endfunction

  function automatic logic [19:0] exp_phys(input logic [15:0] ad);
    if (win(ad)) return {8'hFF, ad[11:0]};
    return {mdl[ad[15:12]], ad[11:0]};
  endfunction

  function automatic logic [7:0] exp_sel(input logic [15:0] ad, input logic v);
    logic [7:0] p;
    if (!v) return 8'h00;
    if (win(ad)) return 8'h01;
    p = mdl[ad[15:12]];
    if (p[3:0] == 4'hF) return 8'h01;
    if (p[3:0] == 4'hE) begin
      if (ad[11:8] != 4'h0) return 8'h00;
      case (ad[7:4])
        4'h0: return 8'h02;
        4'h2: return 8'h04;
        4'h3: return 8'h08;
        4'hA: return 8'h10;
        4'hB: return 8'h20;
        default: return 8'h00;
      endcase
    end
    if (p[7:1] == 7'h06) return 8'h40;
    return 8'h80;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [7:0] s);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 0; k < 8; k++) if (s[k]) r = src[k];
    return r;
  endfunction

  function automatic string sel_tag(input logic [15:0] ad, input logic v);
    logic [7:0] p;
    if (!v) return "R10";
    if (win(ad)) return "R5";
    p = mdl[ad[15:12]];
    if (p[3:0] == 4'hF) return "R6";
    if (p[3:0] == 4'hE) return "R7";
    if (p[7:1] == 7'h06) return "R8";
    return "R9";
  endfunction

  task automatic check(input string req, input string what, input logic [19:0] act,
                       input logic [19:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", req, what, a, act, exp);
    end
  endtask

  // one bus cycle: drive after the falling edge, check before the rising edge
  task automatic apply(input logic [15:0] ad, input logic rwi, input logic vi,
                       input logic [7:0] d, input string ptag);
    logic [7:0] es;
    @(negedge clk);
    a = ad; rw = rwi; vma = vi; wd = d;
    #2;
    es = exp_sel(ad, vi);
    check(win(ad) ? "R5" : ptag, "phys_addr", phys_addr, exp_phys(ad));
    check(sel_tag(ad, vi), "selects", {12'h0, act_sel()}, {12'h0, es});
    check("R11", "cpu_rdata", {12'h0, cpu_rdata}, {12'h0, exp_rdata(es)});
    // R3 R4: model of a register write, visible from the next cycle
    if (vi && !rwi && win(ad)) mdl[ad[3:0]] = {d[7:4], ~d[3:0]};
  endtask

  task automatic sweep(input string ptag);
    for (int p = 0; p < 16; p++) apply({p[3:0], 12'h5A5}, 1'b1, 1'b1, 8'h00, ptag);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] tgt [16];
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 8; k++) src[k] = 8'h11 * 8'(k + 1);
    for (int p = 0; p < 16; p++) mdl[p] = 8'(p);
    rst = 1'b1; a = 16'h1234; rw = 1'b1; vma = 1'b1; wd = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "phys_addr in reset", phys_addr, 20'h01234);
    rst = 1'b0;

    // R1: identity map after reset
    sweep("R1");

    // R3 R4: program a non-identity map; each page read right after its write
    for (int p = 0; p < 16; p++) tgt[p] = 8'($urandom);
    tgt[1] = 8'h0C; tgt[2] = 8'h0D; tgt[4] = 8'h3E; tgt[6] = 8'h7F;
    tgt[8] = 8'h0E; tgt[10] = 8'h1C; tgt[12] = 8'h0F; tgt[15] = 8'h43;
    for (int p = 0; p < 16; p++) begin
      apply(16'hFF00 | 16'(p), 1'b0, 1'b1, {tgt[p][7:4], ~tgt[p][3:0]}, "R3");
      apply({p[3:0], 12'h0C3}, 1'b1, 1'b1, 8'h00, "R4");
    end
    sweep("R2");

    // R5: window ignores remapped page 0xF
    apply(16'hFF37, 1'b1, 1'b1, 8'h00, "R5");
    apply(16'hFFC0, 1'b1, 1'b0, 8'h00, "R5");

    // R7: every slot of the I/O page (page 8 maps to 0x0E, page 4 to 0x3E)
    for (int s = 0; s < 16; s++) apply({4'h8, 4'h0, s[3:0], 4'h6}, 1'b1, 1'b1, 8'h00, "R7");
    apply(16'h4100, 1'b1, 1'b1, 8'h00, "R7");
    apply(16'h40B0, 1'b1, 1'b1, 8'h00, "R7");

    // R12: writes that must not land, then re-sweep
    apply(16'hFF03, 1'b1, 1'b1, 8'hAA, "R12");
    apply(16'hFF04, 1'b0, 1'b0, 8'h55, "R12");
    apply(16'h3004, 1'b0, 1'b1, 8'h99, "R12");
    sweep("R12");

    // R10: idle bus
    for (int p = 0; p < 16; p++) apply({p[3:0], 12'h010}, 1'b1, 1'b0, 8'h00, "R10");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ad;
      logic [31:0] r;
      r = $urandom;
      ad = 16'($urandom);
      if (r[2:0] == 3'd0) ad[15:8] = 8'hFF;
      if (r[5:3] == 3'd1) ad[11:8] = 4'h0;
      if (r[9:6] == 4'd0) src[r[12:10]] = 8'($urandom);
      apply(ad, r[13] | r[14], r[16:15] != 2'b00, 8'($urandom), "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule